// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the software-visible face of a byte-wide serial port. It sits on a plain 32-bit register bus and holds three storage-only control words, a status word that carries the last received byte, an interrupt mask, and the raw and masked interrupt state. It does not shift bits or generate a baud rate. Bytes leave and arrive on two byte streams with valid/ready handshakes, and a single level-sensitive interrupt line reports any interrupt cause that is both raised and enabled.

Software sends a byte by writing the data-out word. The byte passes straight to the transmit stream in that bus cycle and raises the transmit interrupt cause. A byte accepted from the receive stream is latched into the status word, sets the data-available flag and raises the receive cause. Software clears causes by writing ones to the acknowledge word. An acknowledge of the transmit cause while a transmission is still outstanding does not clear the cause; it consumes the outstanding flag instead. The status word can be read in two ways: one clears data-available as a side effect, the other leaves it unchanged.

Top module: `sport_regblock`

## Requirements
- R1: After reset, the status word reads 0x0140_0000 (bit 24 transmitter-ready and bit 22 transmitter-idle set, everything else zero). Every other register reads zero, `irq` is low and `rx_ready` is high.
- R2: Full-word accesses store and read back all 32 bits at these offsets: transmit control 0x00, DMA enable 0x04, receive control 0x08 and interrupt mask 0x2C.
- R3: A byte access (`bus_word`=0), a misaligned offset, an offset of 0x3C or above, or an unlisted offset below it reads as zero, and a write to any of them changes nothing. The acknowledge word at 0x30 always reads zero.
- R4: A full-word write to data-out (0x1C) while `tx_ready` is high drives `tx_valid`=1 and `tx_data`=`bus_wdata[7:0]` in that cycle. After the edge, raw interrupt bit 0 and the internal transmit-pending flag are set. If `tx_ready` is low, the byte is dropped and the raw interrupt is unchanged.
- R5: `rx_ready` is high when receive control bit 0 is set or raw interrupt bit 3 is clear. A byte offered while `rx_ready` is high is accepted: status bits 7:0 take the byte, status bit 16 (data-available) sets and raw interrupt bit 3 sets. A byte offered while `rx_ready` is low leaves the status word unchanged.
- R6: A full-word read at 0x20 returns the status word and then clears bit 16. A read at 0x24 returns the same word and has no side effect.
- R7: A write to the acknowledge word (0x30) clears every raw interrupt bit (read at 0x34) whose written bit is one, apart from the case in R8.
- R8: If the written acknowledge value has bit 0 set while transmit-pending is set, raw bit 0 stays set and transmit-pending clears. A second such acknowledge then clears raw bit 0.
- R9: The masked interrupt word at 0x38 equals the raw word ANDed with the mask. `irq` is high exactly when the masked word is nonzero, starting the cycle after the edge that changes either word.
- R10: When a byte is accepted in the same cycle as an acknowledge of bit 3, raw bit 3 ends up set. When a byte is accepted in the same cycle as a 0x20 read, data-available ends up set and the read returns the word from before the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = full-word access, 0 = byte access |
| bus_addr | input | 6 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as a read strobe |
| tx_valid | output | 1 | Transmit byte offered |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Transmit stream can take a byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Block will accept a receive byte |
| irq | output | 1 | Level interrupt, high while any masked cause is set |

## Verification
Two events can fall in the same cycle: a byte accepted from the receive stream, and a bus access that clears the state that byte sets. That access is either an acknowledge of raw bit 3 or a 0x20 status read that clears data-available. The bench provokes both pairings by raising `rx_valid` during the same cycle as the bus strobe. It then judges the outcome by reading the raw word and the side-effect-free status alias: the new byte's flags must survive, and the colliding read must still return the word from before the edge.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int unsigned BUS_W  = 32;
    localparam int unsigned OFS_W  = 6;
    localparam int unsigned BYTE_W = 8;

    // register offsets (byte addresses within the window)
    localparam logic [OFS_W-1:0] OFS_TXCTL   = 6'h00;
    localparam logic [OFS_W-1:0] OFS_DMAEN   = 6'h04;
    localparam logic [OFS_W-1:0] OFS_RXCTL   = 6'h08;
    localparam logic [OFS_W-1:0] OFS_DOUT    = 6'h1C;
    localparam logic [OFS_W-1:0] OFS_STAT_RC = 6'h20;
    localparam logic [OFS_W-1:0] OFS_STAT    = 6'h24;
    localparam logic [OFS_W-1:0] OFS_MASK    = 6'h2C;
    localparam logic [OFS_W-1:0] OFS_ACK     = 6'h30;
    localparam logic [OFS_W-1:0] OFS_RAW     = 6'h34;
    localparam logic [OFS_W-1:0] OFS_MASKED  = 6'h38;

    // status word fields
    localparam int unsigned STAT_DAV_BIT  = 16;
    localparam int unsigned STAT_IDLE_BIT = 22;
    localparam int unsigned STAT_RDY_BIT  = 24;

    // interrupt cause positions
    localparam int unsigned IRQ_TX_BIT = 0;
    localparam int unsigned IRQ_RX_BIT = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TXCTL,
        SEL_DMAEN,
        SEL_RXCTL,
        SEL_DOUT,
        SEL_STAT_RC,
        SEL_STAT,
        SEL_MASK,
        SEL_ACK,
        SEL_RAW,
        SEL_MASKED
    } reg_sel_e;

    typedef struct packed {
        logic             rd;     // decoded full-word read
        logic             wr;     // decoded full-word write
        reg_sel_e         sel;
        logic [BUS_W-1:0] wdata;
    } bus_op_t;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        case (ofs)
            OFS_TXCTL:   return SEL_TXCTL;
            OFS_DMAEN:   return SEL_DMAEN;
            OFS_RXCTL:   return SEL_RXCTL;
            OFS_DOUT:    return SEL_DOUT;
            OFS_STAT_RC: return SEL_STAT_RC;
            OFS_STAT:    return SEL_STAT;
            OFS_MASK:    return SEL_MASK;
            OFS_ACK:     return SEL_ACK;
            OFS_RAW:     return SEL_RAW;
            OFS_MASKED:  return SEL_MASKED;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic [BUS_W-1:0] status_word(input logic [BYTE_W-1:0] byte_in,
                                                     input logic dav);
        logic [BUS_W-1:0] w;
        w                = '0;
        w[BYTE_W-1:0]    = byte_in;
        w[STAT_DAV_BIT]  = dav;
        w[STAT_IDLE_BIT] = 1'b1;
        w[STAT_RDY_BIT]  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/sport_decode.sv
module sport_decode
    import sport_pkg::*;
(
    input  logic             bus_sel,
    input  logic             bus_we,
    input  logic             bus_word,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output bus_op_t          op
);

    reg_sel_e hit_sel;
    logic     word_acc;

    always_comb begin
        word_acc = bus_sel && bus_word;
        hit_sel  = word_acc ? decode_ofs(bus_addr) : SEL_NONE;
        op.sel   = hit_sel;
        op.rd    = word_acc && !bus_we && (hit_sel != SEL_NONE);
        op.wr    = word_acc &&  bus_we && (hit_sel != SEL_NONE);
        op.wdata = bus_wdata;
    end

endmodule

// File: rtl/sport_rx_latch.sv
module sport_rx_latch
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_enable,
    input  logic              rx_cause,
    input  logic              rd_clear,
    output logic              rx_ready,
    output logic              rx_take,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              dav
);

    always_comb begin
        rx_ready = rx_enable || !rx_cause;
        rx_take  = rx_valid && rx_ready;
    end

    // a byte taken in the same cycle as a clearing read wins
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_byte <= '0;
            dav     <= 1'b0;
        end else if (rx_take) begin
            rx_byte <= rx_data;
            dav     <= 1'b1;
        end else if (rd_clear) begin
            dav     <= 1'b0;
        end
    end

    p_take_latches_r5: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> (dav && rx_byte == $past(rx_data)));

    p_blocked_holds_r5: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |=> $stable(rx_byte));

    p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && !rx_take) |=> !dav);

    p_take_beats_clear_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_clear && rx_take) |=> dav);

endmodule

// File: rtl/sport_irq.sv
module sport_irq
    import sport_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_mask,
    input  logic             wr_ack,
    input  logic [BUS_W-1:0] wdata,
    input  logic             tx_fire,
    input  logic             rx_take,
    output logic [BUS_W-1:0] raw,
    output logic [BUS_W-1:0] mask,
    output logic [BUS_W-1:0] masked,
    output logic             pending,
    output logic             irq
);

    logic [BUS_W-1:0] ack_clr;
    logic [BUS_W-1:0] raw_n;
    logic             rearm;

    always_comb begin
        ack_clr = '0;
        rearm   = 1'b0;
        if (wr_ack) begin
            ack_clr = wdata;
            if (pending && wdata[IRQ_TX_BIT]) begin
                ack_clr[IRQ_TX_BIT] = 1'b0;
                rearm               = 1'b1;
            end
        end
        raw_n = raw & ~ack_clr;
        if (tx_fire) raw_n[IRQ_TX_BIT] = 1'b1;
        if (rx_take) raw_n[IRQ_RX_BIT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw     <= '0;
            mask    <= '0;
            pending <= 1'b0;
        end else begin
            raw <= raw_n;
            if (wr_mask) mask <= wdata;
            if (tx_fire)    pending <= 1'b1;
            else if (rearm) pending <= 1'b0;
        end
    end

    always_comb begin
        masked = raw & mask;
        irq    = |masked;
    end

    p_tx_raises_r4: assert property (@(posedge clk) disable iff (rst)
        tx_fire |=> (raw[IRQ_TX_BIT] && pending));

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && !pending && !rx_take) |=> ((raw & $past(wdata)) == '0));

    p_rearm_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_ack && pending && wdata[IRQ_TX_BIT]) |=> (raw[IRQ_TX_BIT] && !pending));

    p_rx_beats_ack_r10: assert property (@(posedge clk) disable iff (rst)
        rx_take |=> raw[IRQ_RX_BIT]);

    p_irq_follows_mask_r9: assert property (@(posedge clk) disable iff (rst)
        (mask == '0) |-> !irq);

endmodule

// File: rtl/sport_regblock.sv
module sport_regblock
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic              bus_word,
    input  logic [OFS_W-1:0]  bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              irq
);

    bus_op_t           op;
    logic [BUS_W-1:0]  tx_ctrl;
    logic [BUS_W-1:0]  dma_en;
    logic [BUS_W-1:0]  rx_ctrl;
    logic [BUS_W-1:0]  raw;
    logic [BUS_W-1:0]  mask;
    logic [BUS_W-1:0]  masked;
    logic              pending;
    logic              tx_fire;
    logic              rx_take;
    logic [BYTE_W-1:0] rx_byte;
    logic              dav;
    logic              rd_clear;

    sport_decode u_decode (
        .bus_sel   (bus_sel),
        .bus_we    (bus_we),
        .bus_word  (bus_word),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op        (op)
    );

    // data-out goes straight to the stream; dropped if not ready
    always_comb begin
        tx_valid = op.wr && (op.sel == SEL_DOUT);
        tx_data  = op.wdata[BYTE_W-1:0];
        tx_fire  = tx_valid && tx_ready;
        rd_clear = op.rd && (op.sel == SEL_STAT_RC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ctrl <= '0;
            dma_en  <= '0;
            rx_ctrl <= '0;
        end else if (op.wr) begin
            case (op.sel)
                SEL_TXCTL: tx_ctrl <= op.wdata;
                SEL_DMAEN: dma_en  <= op.wdata;
                SEL_RXCTL: rx_ctrl <= op.wdata;
                default: ;
            endcase
        end
    end

    sport_rx_latch u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_valid  (rx_valid),
        .rx_data   (rx_data),
        .rx_enable (rx_ctrl[0]),
        .rx_cause  (raw[IRQ_RX_BIT]),
        .rd_clear  (rd_clear),
        .rx_ready  (rx_ready),
        .rx_take   (rx_take),
        .rx_byte   (rx_byte),
        .dav       (dav)
    );

    sport_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .wr_mask (op.wr && (op.sel == SEL_MASK)),
        .wr_ack  (op.wr && (op.sel == SEL_ACK)),
        .wdata   (op.wdata),
        .tx_fire (tx_fire),
        .rx_take (rx_take),
        .raw     (raw),
        .mask    (mask),
        .masked  (masked),
        .pending (pending),
        .irq     (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (op.rd) begin
            case (op.sel)
                SEL_TXCTL:   bus_rdata = tx_ctrl;
                SEL_DMAEN:   bus_rdata = dma_en;
                SEL_RXCTL:   bus_rdata = rx_ctrl;
                SEL_STAT_RC,
                SEL_STAT:    bus_rdata = status_word(rx_byte, dav);
                SEL_MASK:    bus_rdata = mask;
                SEL_RAW:     bus_rdata = raw;
                SEL_MASKED:  bus_rdata = masked;
                default:     bus_rdata = '0;
            endcase
        end
    end

    p_unmapped_write_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_we && !op.wr) |=>
            ($stable(tx_ctrl) && $stable(dma_en) && $stable(rx_ctrl) && $stable(mask)));

    p_no_tx_when_stalled_r4: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready && !rx_take) |=> $stable(raw));

endmodule

// File: tb/sport_regblock_test.sv
`timescale 1ns/1ps
module sport_regblock_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic        bus_word = 1'b1;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_ready = 1'b1;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    sport_regblock uut (
        .clk(clk), .rst(rst),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .irq(irq)
    );

    // {we, word, addr[5:0], wdata[31:0], expected read[31:0]}
    localparam int NVEC = 19;
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b0, 1'b1, 6'h24, 32'h0,         32'h0140_0000},
        {1'b0, 1'b1, 6'h00, 32'h0,         32'h0},
        {1'b1, 1'b1, 6'h00, 32'hA5A5_0001, 32'h0},
        {1'b0, 1'b1, 6'h00, 32'h0,         32'hA5A5_0001},
        {1'b1, 1'b1, 6'h04, 32'h0000_0003, 32'h0},
        {1'b0, 1'b1, 6'h04, 32'h0,         32'h0000_0003},
        {1'b1, 1'b1, 6'h08, 32'h8000_0000, 32'h0},
        {1'b0, 1'b1, 6'h08, 32'h0,         32'h8000_0000},
        {1'b1, 1'b1, 6'h2C, 32'hF0F0_F0F0, 32'h0},
        {1'b0, 1'b1, 6'h2C, 32'h0,         32'hF0F0_F0F0},
        {1'b1, 1'b1, 6'h10, 32'hDEAD_BEEF, 32'h0},
        {1'b0, 1'b1, 6'h10, 32'h0,         32'h0},
        {1'b0, 1'b1, 6'h3C, 32'h0,         32'h0},
        {1'b0, 1'b0, 6'h00, 32'h0,         32'h0},
        {1'b1, 1'b0, 6'h04, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 1'b1, 6'h04, 32'h0,         32'h0000_0003},
        {1'b0, 1'b1, 6'h30, 32'h0,         32'h0},
        {1'b0, 1'b1, 6'h34, 32'h0,         32'h0},
        {1'b0, 1'b1, 6'h02, 32'h0,         32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        bus_sel = 1'b0;
        rx_valid = 1'b0;
        tx_ready = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d, input logic word);
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
    endtask

    task automatic bus_read(input logic [5:0] a, input logic word, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = word; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_sel = 1'b0; bus_word = 1'b1;
    endtask

    task automatic expect_read(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, 1'b1, d);
        check(req, d, exp);
    endtask

    task automatic rx_push(input logic [7:0] b, output logic acc);
        rx_valid = 1'b1; rx_data = b;
        #1 acc = rx_ready;
        tick();
        rx_valid = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic        acc;

        do_reset();

        // table walk: R1 reset values, R2 storage, R3 unmapped and byte accesses
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][71]) begin
                bus_write(VEC[i][69:64], VEC[i][63:32], VEC[i][70]);
            end else begin
                bus_read(VEC[i][69:64], VEC[i][70], d);
                check($sformatf("R1 R2 R3 table row %0d", i), d, VEC[i][31:0]);
            end
        end

        do_reset();
        check("R1 irq low", {31'b0, irq}, 32'h0);
        check("R1 rx_ready high", {31'b0, rx_ready}, 32'h1);

        // R4 transmit handshake
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = 1'b1; bus_addr = 6'h1C; bus_wdata = 32'h1234_56C3;
        #1;
        check("R4 tx_valid", {31'b0, tx_valid}, 32'h1);
        check("R4 tx_data", {24'b0, tx_data}, 32'h0000_00C3);
        tick();
        bus_sel = 1'b0; bus_we = 1'b0;
        expect_read("R4 raw after send", 6'h34, 32'h1);
        check("R9 irq masked off", {31'b0, irq}, 32'h0);

        bus_write(6'h2C, 32'h9, 1'b1);
        check("R9 irq after mask", {31'b0, irq}, 32'h1);
        expect_read("R9 masked word", 6'h38, 32'h1);

        // R8 acknowledge while pending keeps the cause
        bus_write(6'h30, 32'h1, 1'b1);
        expect_read("R8 raw kept", 6'h34, 32'h1);
        check("R8 irq kept", {31'b0, irq}, 32'h1);
        bus_write(6'h30, 32'h1, 1'b1);
        expect_read("R7 raw cleared", 6'h34, 32'h0);
        check("R7 irq dropped", {31'b0, irq}, 32'h0);

        // R4 dropped when stalled
        tx_ready = 1'b0;
        bus_write(6'h1C, 32'h55, 1'b1);
        expect_read("R4 stalled no cause", 6'h34, 32'h0);
        tx_ready = 1'b1;

        // R5 receive
        rx_push(8'h5A, acc);
        check("R5 first byte accepted", {31'b0, acc}, 32'h1);
        expect_read("R5 status after rx", 6'h24, 32'h0141_005A);
        expect_read("R5 raw rx cause", 6'h34, 32'h8);
        check("R9 irq on rx", {31'b0, irq}, 32'h1);

        // R6 read aliases
        expect_read("R6 clearing read value", 6'h20, 32'h0141_005A);
        expect_read("R6 flag cleared", 6'h24, 32'h0140_005A);
        expect_read("R6 plain read no effect", 6'h24, 32'h0140_005A);

        // R5 back-pressure
        check("R5 rx_ready low", {31'b0, rx_ready}, 32'h0);
        rx_push(8'h77, acc);
        check("R5 byte refused", {31'b0, acc}, 32'h0);
        expect_read("R5 status unchanged", 6'h24, 32'h0140_005A);
        bus_write(6'h08, 32'h1, 1'b1);
        check("R5 rx_ready via enable", {31'b0, rx_ready}, 32'h1);
        rx_push(8'h77, acc);
        expect_read("R5 enabled overwrite", 6'h24, 32'h0141_0077);

        // R10 receive collides with acknowledge of bit 3
        bus_sel = 1'b1; bus_we = 1'b1; bus_word = 1'b1; bus_addr = 6'h30; bus_wdata = 32'h8;
        rx_valid = 1'b1; rx_data = 8'h99;
        tick();
        bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
        expect_read("R10 raw survives ack", 6'h34, 32'h8);
        expect_read("R10 byte latched", 6'h24, 32'h0141_0099);

        // R10 receive collides with clearing read
        bus_sel = 1'b1; bus_we = 1'b0; bus_word = 1'b1; bus_addr = 6'h20;
        rx_valid = 1'b1; rx_data = 8'hAB;
        #1 d = bus_rdata;
        tick();
        bus_sel = 1'b0; rx_valid = 1'b0;
        check("R10 colliding read value", d, 32'h0141_0099);
        expect_read("R10 flag survives read", 6'h24, 32'h0141_00AB);

        // R7 plain acknowledge of bit 3
        bus_write(6'h30, 32'hFFFF_FFF8, 1'b1);
        expect_read("R7 rx cause cleared", 6'h34, 32'h0);
        expect_read("R9 masked zero", 6'h38, 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);

        // R3 byte write to mask ignored
        bus_write(6'h2C, 32'h0, 1'b0);
        expect_read("R3 mask kept", 6'h2C, 32'h9);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule